// File: doc/BRIEF.md
# Cascadable Loadable Synchronous Binary Counter

This block is one stage of a synchronous binary up counter, four bits wide by default. Every flip-flop shares the single clock and changes on its rising edge, so all output bits settle together and no bit waits on a lower one. On each edge the stage does exactly one of four operations: OP_CLEAR sets the count to zero, OP_LOAD copies the parallel data input into the count, OP_COUNT adds one modulo 2^WIDTH, and OP_HOLD keeps the count. A small priority decoder picks the operation and the count register applies it. Clear wins over load, load wins over counting, and counting happens only when both enables are high. The decoder has no stored state. Any combination of inputs can move the stage from any operation to any other on the next edge.

The stage is built for cascading. It has two count enables. The chain enable gates both counting and the terminal-count carry. The local enable gates only counting. To build a wider counter, feed each stage's carry into the next stage's chain enable and share the local enable across all stages. A pause on the local enable then stops every stage, but the carry pattern is kept, so the chain starts again in the right place.

Top module: `syncnt_stage`

## Requirements
- R1: When clr_n is 0 at a rising edge, q is 0 after that edge, whatever load_n, the enables and din are.
- R2: When clr_n is 1 and load_n is 0 at a rising edge, q equals din after that edge, whatever the enables are.
- R3: When clr_n and load_n are 1 and both en_chain and en_local are 1 at a rising edge, q becomes q+1 modulo 2^WIDTH, so the all-ones value 15 wraps to 0.
- R4: When clr_n and load_n are 1 and en_chain or en_local is 0 at a rising edge, q keeps its value.
- R5: carry_out is 1 with no clock delay whenever en_chain is 1 and q is all ones (15). en_local has no effect on carry_out.
- R6: carry_out is 0 whenever en_chain is 0 or q is not all ones.
- R7: Two stages chained this way form an 8-bit counter: low carry_out to the high en_chain, shared en_local, shared clear and load, din split into nibbles. The chain counts through every value, including the step from 0x0F to 0x10 and the wrap from 0xFF to 0x00.
- R8: After a load of 12 with both enables held at 1, q goes 12, 13, 14, 15, 0, 1, 2 on successive edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every state change happens on its rising edge |
| clr_n | input | 1 | Synchronous clear, active low, highest priority |
| load_n | input | 1 | Synchronous parallel load, active low |
| en_chain | input | 1 | Count enable that also gates carry_out; driven by the previous stage's carry |
| en_local | input | 1 | Count enable that does not affect carry_out |
| din | input | WIDTH | Parallel load value |
| q | output | WIDTH | Current count |
| carry_out | output | 1 | Terminal-count flag: en_chain and q all ones |

## Verification
The bench chains two stages into an 8-bit counter and checks it against an arithmetic model. It walks the full count range twice, so it crosses the nibble carry at 0x0F to 0x10 and the wrap at 0xFF to 0x00. If the carry were gated by the local enable, or missing, the high nibble would stall or skip. A counter that saturated instead of wrapping would stick at 0xFF. A sweep over every combination of clear, load and both enables, with a changing data value, finds priority errors: a load that beats clear, or counting while a load is asserted. The bench also parks the count at 0x0F and 0xFF with only the local enable low. There a carry that depended on the wrong enable would change value, and a hold that leaked would move the count.

// File: rtl/syncnt_pkg.sv
package syncnt_pkg;

    // Operation applied by a counter stage on the next rising edge.
    typedef enum logic [1:0] {
        OP_HOLD  = 2'b00,
        OP_COUNT = 2'b01,
        OP_LOAD  = 2'b10,
        OP_CLEAR = 2'b11
    } op_e;

endpackage

// File: rtl/syncnt_ctrl.sv
module syncnt_ctrl
    import syncnt_pkg::*;
(
    input  logic clr_n,
    input  logic load_n,
    input  logic en_chain,
    input  logic en_local,
    output op_e  op
);

    // Priority: clear over load over count; otherwise hold.
    always_comb begin
        if (!clr_n) begin
            op = OP_CLEAR;
        end else if (!load_n) begin
            op = OP_LOAD;
        end else if (en_chain && en_local) begin
            op = OP_COUNT;
        end else begin
            op = OP_HOLD;
        end
    end

endmodule

// File: rtl/syncnt_reg.sv
module syncnt_reg
    import syncnt_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  op_e              op,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] low_ones;
    logic [WIDTH-1:0] q_inc;
    logic [WIDTH-1:0] q_nxt;

    // Synchronous toggle form: bit i flips when every lower bit is one.
    assign low_ones[0] = 1'b1;
    generate
        for (genvar i = 1; i < WIDTH; i++) begin : g_prefix
            assign low_ones[i] = low_ones[i-1] & q[i-1];
        end
        for (genvar i = 0; i < WIDTH; i++) begin : g_toggle
            assign q_inc[i] = q[i] ^ low_ones[i];
        end
    endgenerate

    always_comb begin
        unique case (op)
            OP_CLEAR: q_nxt = '0;
            OP_LOAD:  q_nxt = din;
            OP_COUNT: q_nxt = q_inc;
            OP_HOLD:  q_nxt = q;
            default:  q_nxt = q;
        endcase
    end

    always_ff @(posedge clk) begin
        q <= q_nxt;
    end

endmodule

// File: rtl/syncnt_tc.sv
module syncnt_tc #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] q,
    input  logic             en_chain,
    output logic             carry_out
);

    logic [WIDTH:0] all_ones;

    // AND chain over the count bits, seeded with the chain enable.
    assign all_ones[0] = en_chain;
    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_and
            assign all_ones[i+1] = all_ones[i] & q[i];
        end
    endgenerate

    assign carry_out = all_ones[WIDTH];

endmodule

// File: rtl/syncnt_stage.sv
module syncnt_stage
    import syncnt_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic             load_n,
    input  logic             en_chain,
    input  logic             en_local,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] q,
    output logic             carry_out
);

    op_e op;

    syncnt_ctrl ctrl_i (
        .clr_n    (clr_n),
        .load_n   (load_n),
        .en_chain (en_chain),
        .en_local (en_local),
        .op       (op)
    );

    syncnt_reg #(.WIDTH(WIDTH)) reg_i (
        .clk (clk),
        .op  (op),
        .din (din),
        .q   (q)
    );

    syncnt_tc #(.WIDTH(WIDTH)) tc_i (
        .q         (q),
        .en_chain  (en_chain),
        .carry_out (carry_out)
    );

endmodule

// File: rtl/syncnt_stage_chk.sv
module syncnt_stage_chk #(
    parameter int WIDTH = 4
) (
    input logic             clk,
    input logic             clr_n,
    input logic             load_n,
    input logic             en_chain,
    input logic             en_local,
    input logic [WIDTH-1:0] din,
    input logic [WIDTH-1:0] q,
    input logic             carry_out
);

    localparam logic [WIDTH-1:0] TOP = {WIDTH{1'b1}};

    // The count is only defined once a clear has been taken.
    logic primed = 1'b0;
    always_ff @(posedge clk) begin
        if (!clr_n) primed <= 1'b1;
    end

    p_clear_r1: assert property (@(posedge clk) disable iff (!primed)
        !clr_n |=> q == '0);

    p_load_r2: assert property (@(posedge clk) disable iff (!primed)
        (clr_n && !load_n) |=> q == $past(din));

    p_count_r3: assert property (@(posedge clk) disable iff (!primed)
        (clr_n && load_n && en_chain && en_local) |=> q == WIDTH'($past(q) + 1'b1));

    p_hold_r4: assert property (@(posedge clk) disable iff (!primed)
        (clr_n && load_n && !(en_chain && en_local)) |=> $stable(q));

    p_carry_set_r5: assert property (@(posedge clk) disable iff (!primed)
        (en_chain && q == TOP) |-> carry_out);

    p_carry_clr_r6: assert property (@(posedge clk) disable iff (!primed)
        carry_out |-> (en_chain && q == TOP));

endmodule

bind syncnt_stage syncnt_stage_chk #(.WIDTH(WIDTH)) chk_i (
    .clk       (clk),
    .clr_n     (clr_n),
    .load_n    (load_n),
    .en_chain  (en_chain),
    .en_local  (en_local),
    .din       (din),
    .q         (q),
    .carry_out (carry_out)
);

// File: tb/syncnt_stage_tb_top.sv
module syncnt_stage_tb_top;

    logic       clk = 1'b0;
    logic       clr_n = 1'b0;
    logic       load_n = 1'b1;
    logic       en_t = 1'b1;
    logic       en_p = 1'b1;
    logic [7:0] din = 8'h00;
    logic [3:0] q_lo, q_hi;
    logic       c_lo, c_hi;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 1'b0;
    logic [7:0] model = 8'h00;

    always #4 clk = ~clk;

    syncnt_stage #(.WIDTH(4)) dut_i (
        .clk(clk), .clr_n(clr_n), .load_n(load_n), .en_chain(en_t),
        .en_local(en_p), .din(din[3:0]), .q(q_lo), .carry_out(c_lo)
    );

    syncnt_stage #(.WIDTH(4)) dut_hi_i (
        .clk(clk), .clr_n(clr_n), .load_n(load_n), .en_chain(c_lo),
        .en_local(en_p), .din(din[7:4]), .q(q_hi), .carry_out(c_hi)
    );

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // One clock: drive at the falling edge, check carries, take the edge,
    // update the model, check the count at the next falling edge.
    task automatic cyc(logic c, logic l, logic [7:0] d, logic t, logic p, string tag);
        logic [1:0] exp_c;
        string      qtag;
        string      ctag;
        clr_n = c; load_n = l; din = d; en_t = t; en_p = p;
        #1;
        exp_c[0] = t && (model[3:0] == 4'hF);
        exp_c[1] = exp_c[0] && (model[7:4] == 4'hF);
        ctag = (exp_c != 2'b11) ? "R6 carry" : "R5 carry";
        if (exp_c[0]) ctag = "R5 carry";
        check(ctag, {6'd0, c_hi, c_lo}, {6'd0, exp_c});
        @(posedge clk);
        if (!c)         begin model = 8'h00;        qtag = "R1 clear"; end
        else if (!l)    begin model = d;            qtag = "R2 load";  end
        else if (t && p) begin model = model + 8'd1; qtag = "R3 count"; end
        else            qtag = "R4 hold";
        if (tag != "") qtag = tag;
        @(negedge clk);
        check(qtag, {q_hi, q_lo}, model);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        // R1: clear beats load and enables
        cyc(1'b0, 1'b0, 8'hA5, 1'b1, 1'b1, "R1 clear over load");
        // R8: preset 12 then count
        cyc(1'b1, 1'b0, 8'h0C, 1'b0, 1'b0, "R2 load 12");
        for (int i = 0; i < 6; i++) cyc(1'b1, 1'b1, 8'h00, 1'b1, 1'b1, "R8 sequence");
        // R7: full 8-bit sweep twice from zero
        cyc(1'b0, 1'b1, 8'h00, 1'b1, 1'b1, "R1 clear");
        for (int i = 0; i < 520; i++) cyc(1'b1, 1'b1, 8'h00, 1'b1, 1'b1, "R7 chain count");
        // R5: park at 0x0F and 0xFF with local enable low
        cyc(1'b1, 1'b0, 8'h0F, 1'b0, 1'b1, "R2 load ignores enables");
        for (int i = 0; i < 3; i++) cyc(1'b1, 1'b1, 8'h00, 1'b1, 1'b0, "R4 hold local low");
        cyc(1'b1, 1'b1, 8'h00, 1'b0, 1'b1, "R4 hold chain low");
        cyc(1'b1, 1'b1, 8'h00, 1'b1, 1'b1, "R7 step 0F to 10");
        cyc(1'b1, 1'b0, 8'hFF, 1'b1, 1'b0, "R2 load FF");
        cyc(1'b1, 1'b1, 8'h00, 1'b1, 1'b0, "R4 hold at FF");
        cyc(1'b1, 1'b1, 8'h00, 1'b1, 1'b1, "R7 wrap FF to 00");
        // Priority sweep over all control combinations
        for (int r = 0; r < 3; r++) begin
            for (int k = 0; k < 16; k++) begin
                cyc(k[3], k[2], 8'(k * 37 + r * 91 + 5), k[1], k[0], "");
                cyc(1'b1, 1'b1, 8'h00, 1'b1, 1'b1, "");
            end
        end
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule